// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the two error counters of a CAN controller and derives from them the fault confinement state of the node: error-active, error-passive or bus-off. The protocol engine drives one-cycle event pulses into it: transmit error, receive error, acknowledge error, successful transmit and successful receive. While the node is bus-off, the engine also presents each sampled bus bit together with a strobe. The block outputs both counters, a two-bit state code and a one-cycle interrupt pulse on entry to bus-off.

Recovery from bus-off reuses the transmit counter. A run counter counts consecutive recessive bits, and each completed run of eleven adds one to the transmit counter. An acknowledge error counts only while the node is error-active. As a result, a node that is alone on the bus settles in error-passive and never reaches bus-off.

A host write port can load both counters, but only in freeze mode. The port is valid/ready. Ready is high only while freeze is asserted and no earlier transfer is still in flight. A valid that arrives without ready is dropped and is not held. An accepted word is parked in an auxiliary register. It is then committed by a toggle request and a toggle acknowledge, each passed through a synchronizer of `SYNC` stages. Busy stays high until the acknowledge returns.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, both counters are 0 and the state code is 00. `host_rdata` carries the transmit counter in bits [7:0] and the receive counter in bits [15:8].
- R2: A transmit error adds 8 to the transmit counter and a receive error adds 1 to the receive counter, which saturates at 255. A successful transmit or receive subtracts 1 from its counter, never going below 0. If an error and a success for the same counter fall in the same cycle, only the error counts.
- R3: When not bus-off, the state code is 01 (error-passive) whenever either counter is 128 or more.
- R4: The state returns to 00 (error-active) only when both counters are 127 or less.
- R5: An acknowledge error adds 8 to the transmit counter in error-active and leaves it unchanged in error-passive.
- R6: A transmit increment that would take the transmit counter above 255 puts the node in bus-off. The state code becomes 10, the transmit counter becomes 0, the receive counter keeps its value, and `busoff_irq` is high for exactly that one cycle.
- R7: While bus-off, error, success and acknowledge events have no effect on either counter.
- R8: While bus-off, each strobed recessive bit (`bit_recessive`=1) extends a run. A strobed dominant bit clears the run. The 11th consecutive recessive bit adds 1 to the transmit counter and starts a new run. Bits without a strobe are ignored.
- R9: When a recovery step would bring the transmit counter to 128, the state code becomes 00 and both counters become 0.
- R10: `host_wr_ready` is high only when `freeze` is high and `host_busy` is low. A valid without ready changes nothing.
- R11: An accepted write loads the transmit counter from data bits [7:0] and the receive counter from bits [15:8]. The load happens on the (SYNC+1)th clock edge after acceptance and overrides any event on that edge. `host_busy` is high for 2*SYNC+1 cycles starting after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err | input | 1 | Transmit error pulse |
| rx_err | input | 1 | Receive error pulse |
| tx_ok | input | 1 | Successful transmit pulse |
| rx_ok | input | 1 | Successful receive pulse |
| ack_err | input | 1 | Acknowledge error pulse |
| bit_strobe | input | 1 | Sampled bus bit is valid this cycle |
| bit_recessive | input | 1 | Sampled bus bit, 1 = recessive |
| freeze | input | 1 | Freeze mode, enables host writes |
| host_wr_valid | input | 1 | Host write request |
| host_wr_ready | output | 1 | Host write accepted this cycle |
| host_wr_data | input | 16 | [7:0] transmit counter, [15:8] receive counter |
| host_busy | output | 1 | Write commit in flight |
| host_rdata | output | 16 | Committed counters, same layout as the write data |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| fc_state | output | 2 | 00 active, 01 passive, 10 bus-off |
| busoff_irq | output | 1 | One-cycle pulse on entry to bus-off |

## Verification
Two functions can land on the same clock edge: the staged host commit and the event-driven counter update. To provoke this, the bench holds a receive error high continuously from the cycle of write acceptance until busy falls, so one edge carries both a commit and an event. The commit must win on its edge, so the final receive count must equal the written value plus exactly SYNC. The bench also counts the busy cycles against 2*SYNC+1.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

  typedef struct packed {
    logic tx_err;
    logic rx_err;
    logic tx_ok;
    logic rx_ok;
    logic ack_err;
  } fc_events_t;
endpackage

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int RUN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busoff,
  input  logic bit_strobe,
  input  logic bit_recessive,
  output logic step
);
  localparam int SW = $clog2(RUN);
  localparam logic [SW-1:0] LAST = SW'(RUN - 1);

  logic [SW-1:0] run_q;

  // one recovery step per completed recessive run
  assign step = busoff && bit_strobe && bit_recessive && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !busoff) begin
      run_q <= '0;
    end else if (bit_strobe) begin
      if (!bit_recessive || step) run_q <= '0;
      else                        run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_fc_host_xfer.sv
module can_fc_host_xfer #(
  parameter int CW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [CW-1:0] wr_tec,
  input  logic [CW-1:0] wr_rec,
  output logic          commit,
  output logic [CW-1:0] commit_tec,
  output logic [CW-1:0] commit_rec,
  output logic          busy
);
  logic            req_tgl, ack_tgl;
  logic [SYNC-1:0] req_pipe, ack_pipe;
  logic [CW-1:0]   aux_tec, aux_rec;

  assign busy       = req_tgl != ack_pipe[SYNC-1];
  assign wr_ready   = freeze && !busy;
  assign commit     = req_pipe[SYNC-1] != ack_tgl;
  assign commit_tec = aux_tec;
  assign commit_rec = aux_rec;

  // host side: park data, flip request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      aux_tec <= '0;
      aux_rec <= '0;
    end else if (wr_valid && wr_ready) begin
      req_tgl <= ~req_tgl;
      aux_tec <= wr_tec;
      aux_rec <= wr_rec;
    end
  end

  // counter side: synchronize request, flip acknowledge on commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pipe <= '0;
      ack_pipe <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      req_pipe <= {req_pipe[SYNC-2:0], req_tgl};
      ack_pipe <= {ack_pipe[SYNC-2:0], ack_tgl};
      if (commit) ack_tgl <= ~ack_tgl;
    end
  end
endmodule

// File: rtl/can_fc_counters.sv
module can_fc_counters
  import can_fc_pkg::*;
#(
  parameter int CW        = 8,
  parameter int TX_STEP   = 8,
  parameter int RECOV_LIM = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fc_events_t    ev,
  input  logic          rec_step,
  input  logic          commit,
  input  logic [CW-1:0] commit_tec,
  input  logic [CW-1:0] commit_rec,
  output logic [CW-1:0] tec,
  output logic [CW-1:0] rec,
  output fc_state_e     state,
  output logic          busoff,
  output logic          irq
);
  localparam logic [CW:0]   TEC_MAX = {1'b0, {CW{1'b1}}};
  localparam logic [CW:0]   STEP_X  = (CW+1)'(TX_STEP);
  localparam logic [CW-1:0] REC_END = CW'(RECOV_LIM - 1);

  logic [CW-1:0] tec_n, rec_n;
  logic          boff_n, irq_n;
  logic          passive, tx_hit;
  logic [CW:0]   tx_sum;

  // the passive threshold is half the counter range: the counter MSB
  assign passive = tec[CW-1] | rec[CW-1];
  assign tx_hit  = ev.tx_err | (ev.ack_err & ~passive);
  assign tx_sum  = {1'b0, tec} + STEP_X;

  always_comb begin
    tec_n  = tec;
    rec_n  = rec;
    boff_n = busoff;
    irq_n  = 1'b0;
    if (commit) begin
      tec_n = commit_tec;
      rec_n = commit_rec;
    end else if (busoff) begin
      if (rec_step) begin
        if (tec == REC_END) begin
          boff_n = 1'b0;
          tec_n  = '0;
          rec_n  = '0;
        end else begin
          tec_n = tec + 1'b1;
        end
      end
    end else begin
      if (tx_hit) begin
        if (tx_sum > TEC_MAX) begin
          boff_n = 1'b1;
          irq_n  = 1'b1;
          tec_n  = '0;
        end else begin
          tec_n = tx_sum[CW-1:0];
        end
      end else if (ev.tx_ok && tec != '0) begin
        tec_n = tec - 1'b1;
      end
      if (ev.rx_err) begin
        if (rec != '1) rec_n = rec + 1'b1;
      end else if (ev.rx_ok && rec != '0) begin
        rec_n = rec - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec    <= '0;
      rec    <= '0;
      busoff <= 1'b0;
      irq    <= 1'b0;
    end else begin
      tec    <= tec_n;
      rec    <= rec_n;
      busoff <= boff_n;
      irq    <= irq_n;
    end
  end

  always_comb begin
    if (busoff)       state = FC_BUSOFF;
    else if (passive) state = FC_PASSIVE;
    else              state = FC_ACTIVE;
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int CW        = 8,
  parameter int TX_STEP   = 8,
  parameter int RUN       = 11,
  parameter int RECOV_LIM = 128,
  parameter int SYNC      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_err,
  input  logic            rx_err,
  input  logic            tx_ok,
  input  logic            rx_ok,
  input  logic            ack_err,
  input  logic            bit_strobe,
  input  logic            bit_recessive,
  input  logic            freeze,
  input  logic            host_wr_valid,
  output logic            host_wr_ready,
  input  logic [2*CW-1:0] host_wr_data,
  output logic            host_busy,
  output logic [2*CW-1:0] host_rdata,
  output logic [CW-1:0]   tec,
  output logic [CW-1:0]   rec,
  output logic [1:0]      fc_state,
  output logic            busoff_irq
);
  fc_events_t    ev;
  fc_state_e     state;
  logic          busoff, rec_step, commit;
  logic [CW-1:0] c_tec, c_rec;

  assign ev = '{tx_err: tx_err, rx_err: rx_err, tx_ok: tx_ok,
                rx_ok: rx_ok, ack_err: ack_err};

  can_fc_recovery #(.RUN(RUN)) u_recov (
    .clk(clk), .rst_n(rst_n), .busoff(busoff),
    .bit_strobe(bit_strobe), .bit_recessive(bit_recessive), .step(rec_step)
  );

  can_fc_host_xfer #(.CW(CW), .SYNC(SYNC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .wr_valid(host_wr_valid), .wr_ready(host_wr_ready),
    .wr_tec(host_wr_data[CW-1:0]), .wr_rec(host_wr_data[2*CW-1:CW]),
    .commit(commit), .commit_tec(c_tec), .commit_rec(c_rec), .busy(host_busy)
  );

  can_fc_counters #(.CW(CW), .TX_STEP(TX_STEP), .RECOV_LIM(RECOV_LIM)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ev(ev), .rec_step(rec_step),
    .commit(commit), .commit_tec(c_tec), .commit_rec(c_rec),
    .tec(tec), .rec(rec), .state(state), .busoff(busoff), .irq(busoff_irq)
  );

  assign fc_state   = state;
  assign host_rdata = {rec, tec};
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_err,
  input logic       tx_ok,
  input logic       ack_err,
  input logic       bit_strobe,
  input logic       freeze,
  input logic       host_wr_ready,
  input logic       host_busy,
  input logic [7:0] tec,
  input logic [7:0] rec,
  input logic [1:0] fc_state,
  input logic       busoff_irq
);
  p_passive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_state[1] && (tec >= 8'd128 || rec >= 8'd128)) |-> fc_state == 2'b01);

  p_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fc_state == 2'b00 |-> (tec <= 8'd127 && rec <= 8'd127));

  p_tx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_state[1] && tx_err && !host_busy && tec < 8'd248) |=> tec == $past(tec) + 8'd8);

  p_ack_passive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state == 2'b01 && ack_err && !tx_err && !tx_ok && !host_busy) |=> tec == $past(tec));

  p_irq_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_irq |-> (fc_state == 2'b10 && tec == 8'd0));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_irq |=> !busoff_irq);

  p_busoff_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state[1] && !bit_strobe && !host_busy) |=> (fc_state[1] && $stable(tec) && $stable(rec)));

  p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_ready |-> (freeze && !host_busy));

  p_no_code3_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fc_state != 2'b11);
endmodule

bind can_fault_conf can_fc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok), .ack_err(ack_err),
  .bit_strobe(bit_strobe), .freeze(freeze), .host_wr_ready(host_wr_ready),
  .host_busy(host_busy), .tec(tec), .rec(rec), .fc_state(fc_state),
  .busoff_irq(busoff_irq)
);

// File: tb/can_fault_conf_tb.sv
`timescale 1ns/1ps
module can_fault_conf_tb;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, ack_err = 0;
  logic        bit_strobe = 0, bit_recessive = 0;
  logic        freeze = 0, host_wr_valid = 0;
  logic [15:0] host_wr_data = '0;
  logic        host_wr_ready, host_busy, busoff_irq;
  logic [15:0] host_rdata;
  logic [7:0]  tec, rec;
  logic [1:0]  fc_state;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_fault_conf #(.SYNC(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err), .tx_ok(tx_ok),
    .rx_ok(rx_ok), .ack_err(ack_err), .bit_strobe(bit_strobe),
    .bit_recessive(bit_recessive), .freeze(freeze), .host_wr_valid(host_wr_valid),
    .host_wr_ready(host_wr_ready), .host_wr_data(host_wr_data), .host_busy(host_busy),
    .host_rdata(host_rdata), .tec(tec), .rec(rec), .fc_state(fc_state),
    .busoff_irq(busoff_irq)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic ev(input logic te, input logic re, input logic to,
                    input logic ro, input logic ae);
    tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; ack_err = ae;
    @(negedge clk);
    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; ack_err = 0;
  endtask

  task automatic bit_in(input logic v, input logic s);
    bit_recessive = v; bit_strobe = s;
    @(negedge clk);
    bit_strobe = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tec after reset", tec, 0);
    chk("R1 rec after reset", rec, 0);
    chk("R1 state after reset", fc_state, 0);
    chk("R1 irq after reset", busoff_irq, 0);
    chk("R1 rdata after reset", host_rdata, 0);

    // R5 ack error while active
    ev(0, 0, 0, 0, 1);
    chk("R5 ack error active", tec, 8);
    // R2 decrement and floor
    for (int i = 0; i < 9; i++) ev(0, 0, 1, 0, 0);
    chk("R2 tx floor at zero", tec, 0);
    ev(1, 0, 1, 0, 0);
    chk("R2 tx error wins over tx ok", tec, 8);
    ev(0, 1, 0, 1, 0);
    chk("R2 rx error wins over rx ok", rec, 1);
    ev(0, 0, 0, 1, 0);
    ev(0, 0, 0, 1, 0);
    chk("R2 rx floor at zero", rec, 0);
    chk("R1 rdata layout", host_rdata, 16'h0008);

    // R3 transmit ramp to passive
    for (int k = 2; k <= 16; k++) begin
      ev(1, 0, 0, 0, 0);
      chk("R2 tx ramp value", tec, 8 * k);
      chk("R3 state on tx ramp", fc_state, (8 * k >= 128) ? 1 : 0);
    end
    ev(0, 0, 0, 0, 1);
    chk("R5 ack error ignored when passive", tec, 128);
    ev(0, 0, 1, 0, 0);
    chk("R4 back to active at tec 127", fc_state, 0);

    // R3 receive ramp
    for (int i = 0; i < 127; i++) ev(0, 1, 0, 0, 0);
    chk("R3 state at rec 127", fc_state, 0);
    ev(0, 1, 0, 0, 0);
    chk("R3 rec reaches 128", rec, 128);
    chk("R3 passive from rec", fc_state, 1);
    ev(1, 0, 0, 0, 0);
    ev(0, 0, 0, 1, 0);
    chk("R4 rec 127 but tec 135 stays passive", fc_state, 1);

    // R6 bus-off entry
    for (int i = 0; i < 15; i++) ev(1, 0, 0, 0, 0);
    chk("R6 tec at 255", tec, 255);
    ev(1, 0, 0, 0, 0);
    chk("R6 state bus-off", fc_state, 2);
    chk("R6 tec cleared", tec, 0);
    chk("R6 rec kept", rec, 127);
    chk("R6 irq pulse", busoff_irq, 1);
    @(negedge clk);
    chk("R6 irq one cycle", busoff_irq, 0);

    // R7 events ignored while bus-off
    ev(1, 1, 0, 0, 0);
    ev(0, 0, 1, 1, 1);
    chk("R7 tec unchanged in bus-off", tec, 0);
    chk("R7 rec unchanged in bus-off", rec, 127);

    // R8 recovery run counting
    for (int i = 0; i < 10; i++) bit_in(1, 1);
    bit_in(0, 1);
    for (int i = 0; i < 10; i++) bit_in(1, 1);
    chk("R8 dominant clears run", tec, 0);
    bit_in(1, 0);
    chk("R8 unstrobed bit ignored", tec, 0);
    bit_in(1, 1);
    chk("R8 eleventh recessive steps", tec, 1);
    for (int g = 0; g < 126; g++) repeat (11) bit_in(1, 1);
    chk("R8 tec 127 in bus-off", tec, 127);
    chk("R9 still bus-off at 127", fc_state, 2);
    for (int i = 0; i < 11; i++) bit_in(1, 1);
    chk("R9 recovered state", fc_state, 0);
    chk("R9 tec cleared", tec, 0);
    chk("R9 rec cleared", rec, 0);

    // R10 write without freeze is dropped
    host_wr_data = {8'd250, 8'd200};
    host_wr_valid = 1;
    chk("R10 ready low without freeze", host_wr_ready, 0);
    repeat (8) @(negedge clk);
    host_wr_valid = 0;
    chk("R10 tec untouched", tec, 0);
    chk("R10 busy stays low", host_busy, 0);

    // R11 staged commit racing receive errors
    freeze = 1;
    @(negedge clk);
    chk("R10 ready with freeze", host_wr_ready, 1);
    host_wr_valid = 1;
    rx_err = 1;
    @(negedge clk);
    host_wr_valid = 0;
    chk("R10 ready low while busy", host_wr_ready, 0);
    cnt = 0;
    while (host_busy && cnt < 50) begin
      cnt++;
      @(negedge clk);
    end
    rx_err = 0;
    chk("R11 busy length", cnt, 2 * SYNC + 1);
    chk("R11 tec loaded", tec, 200);
    chk("R11 rec loaded then counted", rec, 250 + SYNC);
    chk("R11 rdata committed", host_rdata, {8'(250 + SYNC), 8'd200});
    chk("R3 passive after load", fc_state, 1);
    for (int i = 0; i < 4; i++) ev(0, 1, 0, 0, 0);
    chk("R2 rec saturates", rec, 255);

    done = 1;
    finish_run();
  end
endmodule